// File: doc/BRIEF.md
# CAN Controller Sleep Sequencer

This block decides when a CAN protocol controller may go to sleep, and when it wakes again. Software sets a sleep-request level in the CPU bus clock domain. The request is synchronized into the CAN clock domain. There, a small state machine waits until the controller can stop safely: no transmit buffer is still pending and no frame is being received. It then enters sleep. The sleep state is synchronized back into the bus domain as an acknowledge flag, which software polls to complete the handshake.

While asleep, the block drops the clock enable of the protocol engine. This also freezes everything the engine counts, including the bus-off recovery count. The block holds the transmit pin at the recessive level. It either passes the receive pin through or masks it, depending on a wake-up enable that was captured at the moment sleep was entered. When the wake-up enable is armed, the first dominant level on the receive pin during a sleep episode raises a sticky wake-up interrupt flag in the bus domain. Software clears the request to leave sleep. The acknowledge then falls once the exit has crossed back.

Top module: `canslp_top`

## Requirements
- R1: After reset, `sleepAck` and `wakeIrq` are 0 and `protoClkEn` is 1. `txPinOut` equals `engineTx` and `rxInternal` equals `canRxPin`.
- R2: A request that arrives when every `txEmpty` bit is 1 and `rxBusy` is 0 enters sleep without further waiting, and `sleepAck` rises within 20 bus cycles.
- R3: While any `txEmpty` bit is 0 (a buffer is pending), sleep is not entered. Sleep follows once all bits are 1.
- R4: A request that arrives while `rxBusy` is 1 defers sleep until `rxBusy` is 0 and `busIdle` is 1 together.
- R5: `sleepAck` rises only after the CAN-domain side is asleep (`protoClkEn` already 0). Every acknowledge change matches a change the handshake calls for.
- R6: While asleep, `protoClkEn` is 0 and `txPinOut` is 1 (recessive) whatever `engineTx` is.
- R7: If `wakeEnable` was 0 when sleep was entered, `rxInternal` is held at 1 and `wakeIrq` stays 0 during that episode. This holds even if `wakeEnable` is set later.
- R8: If `wakeEnable` was 1 when sleep was entered, `rxInternal` follows `canRxPin`. The first 0 (dominant) on `canRxPin` in the episode sets `wakeIrq`. `wakeIrq` stays set until a one-cycle `wakeIrqClr` pulse, and a later dominant level in the same episode does not set it again.
- R9: Clearing `sleepReq` while asleep restores `protoClkEn` to 1 and `txPinOut` to `engineTx`, and `sleepAck` falls.
- R10: Clearing `sleepReq` while sleep is still deferred returns to normal operation without any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | CPU bus clock |
| busRstN | input | 1 | Active-low reset, bus domain |
| sleepReq | input | 1 | Sleep request register bit (bus domain) |
| wakeEnable | input | 1 | Wake-up enable register bit (bus domain) |
| wakeIrqClr | input | 1 | One-cycle clear of the wake-up flag |
| sleepAck | output | 1 | Synchronized sleep acknowledge |
| wakeIrq | output | 1 | Sticky wake-up interrupt flag |
| canClk | input | 1 | CAN protocol clock |
| canRstN | input | 1 | Active-low reset, CAN domain |
| txEmpty | input | NUM_TX | Per-buffer transmit empty flags (1 = empty) |
| rxBusy | input | 1 | A frame is being received |
| busIdle | input | 1 | The bus is idle |
| engineTx | input | 1 | Transmit level from the protocol engine |
| canRxPin | input | 1 | Receive pin level (0 = dominant) |
| protoClkEn | output | 1 | Clock enable of the protocol engine |
| txPinOut | output | 1 | Transmit pin level |
| rxInternal | output | 1 | Receive level seen by the protocol engine |

## Verification
Two situations are hard to reach from the ports. The first is an unarmed sleep episode in which software sets the wake-up enable only after entry. The stimulus requests sleep with the enable low, waits for the acknowledge, and then raises the enable and drives a dominant level. The bench must see the receive line stay masked and no flag appear. The second is a request withdrawn while a pending buffer still defers entry. The buffer is drained only after the withdrawal, and the scoreboard must then record no acknowledge edge at all.

// File: rtl/canslp_pkg.sv
package canslp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SLEEP = 2'd2
  } slpState_t;

  typedef struct packed {
    logic asleep;
    logic enterSleep;
    logic leaveSleep;
  } slpStrobe_t;
endpackage

// File: rtl/canslp_sync.sv
module canslp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/canslp_ctrl.sv
module canslp_ctrl
  import canslp_pkg::*;
#(
  parameter int NUM_TX = 3
) (
  input  logic              canClk,
  input  logic              canRstN,
  input  logic              reqSync,
  input  logic [NUM_TX-1:0] txEmpty,
  input  logic              rxBusy,
  input  logic              busIdle,
  output slpStrobe_t        strobes
);
  slpState_t state, nextState;
  logic allEmpty;

  assign allEmpty = &txEmpty;

  always_comb begin
    nextState = state;
    case (state)
      ST_RUN: begin
        if (reqSync) begin
          if (allEmpty && !rxBusy) nextState = ST_SLEEP;
          else                     nextState = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!reqSync)                           nextState = ST_RUN;
        else if (allEmpty && !rxBusy && busIdle) nextState = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!reqSync) nextState = ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) state <= ST_RUN;
    else          state <= nextState;
  end

  always_comb begin
    strobes.asleep     = (state == ST_SLEEP);
    strobes.enterSleep = (state != ST_SLEEP) && (nextState == ST_SLEEP);
    strobes.leaveSleep = (state == ST_SLEEP) && (nextState != ST_SLEEP);
  end
endmodule

// File: rtl/canslp_dp.sv
module canslp_dp
  import canslp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       busClk,
  input  logic       busRstN,
  input  logic       sleepReq,
  input  logic       wakeEnable,
  input  logic       wakeIrqClr,
  output logic       sleepAck,
  output logic       wakeIrq,
  input  logic       canClk,
  input  logic       canRstN,
  input  logic       engineTx,
  input  logic       canRxPin,
  input  slpStrobe_t strobes,
  output logic       reqSync,
  output logic       protoClkEn,
  output logic       txPinOut,
  output logic       rxInternal
);
  logic wakeEnSync;
  logic wakeArmed;
  logic wakeSeen;
  logic wakeTgl;
  logic wakeTglBus;
  logic wakeTglLast;

  // bus -> CAN crossings
  canslp_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(canClk), .rstN(canRstN), .d(sleepReq), .q(reqSync));
  canslp_sync #(.STAGES(SYNC_STAGES)) u_wenSync (
    .clk(canClk), .rstN(canRstN), .d(wakeEnable), .q(wakeEnSync));

  // CAN -> bus crossings
  canslp_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(busClk), .rstN(busRstN), .d(strobes.asleep), .q(sleepAck));
  canslp_sync #(.STAGES(SYNC_STAGES)) u_wakeSync (
    .clk(busClk), .rstN(busRstN), .d(wakeTgl), .q(wakeTglBus));

  // wake-up arming and one-shot detection in the CAN domain
  always_ff @(posedge canClk or negedge canRstN) begin
    if (!canRstN) begin
      wakeArmed <= 1'b0;
      wakeSeen  <= 1'b0;
      wakeTgl   <= 1'b0;
    end else begin
      if (strobes.enterSleep) begin
        wakeArmed <= wakeEnSync;
        wakeSeen  <= 1'b0;
      end else if (strobes.leaveSleep) begin
        wakeArmed <= 1'b0;
      end else if (strobes.asleep && wakeArmed && !canRxPin && !wakeSeen) begin
        wakeSeen <= 1'b1;
        wakeTgl  <= ~wakeTgl;
      end
    end
  end

  // sticky wake flag in the bus domain, a new event wins over a clear
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      wakeTglLast <= 1'b0;
      wakeIrq     <= 1'b0;
    end else begin
      wakeTglLast <= wakeTglBus;
      if (wakeTglBus != wakeTglLast) wakeIrq <= 1'b1;
      else if (wakeIrqClr)           wakeIrq <= 1'b0;
    end
  end

  // pin gating
  assign protoClkEn = !strobes.asleep;
  assign txPinOut   = strobes.asleep | engineTx;
  assign rxInternal = (strobes.asleep && !wakeArmed) ? 1'b1 : canRxPin;
endmodule

// File: rtl/canslp_top.sv
module canslp_top
  import canslp_pkg::*;
#(
  parameter int NUM_TX      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              sleepReq,
  input  logic              wakeEnable,
  input  logic              wakeIrqClr,
  output logic              sleepAck,
  output logic              wakeIrq,
  input  logic              canClk,
  input  logic              canRstN,
  input  logic [NUM_TX-1:0] txEmpty,
  input  logic              rxBusy,
  input  logic              busIdle,
  input  logic              engineTx,
  input  logic              canRxPin,
  output logic              protoClkEn,
  output logic              txPinOut,
  output logic              rxInternal
);
  slpStrobe_t strobes;
  logic       reqSync;

  canslp_ctrl #(.NUM_TX(NUM_TX)) u_ctrl (
    .canClk  (canClk),
    .canRstN (canRstN),
    .reqSync (reqSync),
    .txEmpty (txEmpty),
    .rxBusy  (rxBusy),
    .busIdle (busIdle),
    .strobes (strobes)
  );

  canslp_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .busClk     (busClk),
    .busRstN    (busRstN),
    .sleepReq   (sleepReq),
    .wakeEnable (wakeEnable),
    .wakeIrqClr (wakeIrqClr),
    .sleepAck   (sleepAck),
    .wakeIrq    (wakeIrq),
    .canClk     (canClk),
    .canRstN    (canRstN),
    .engineTx   (engineTx),
    .canRxPin   (canRxPin),
    .strobes    (strobes),
    .reqSync    (reqSync),
    .protoClkEn (protoClkEn),
    .txPinOut   (txPinOut),
    .rxInternal (rxInternal)
  );
endmodule

// File: rtl/canslp_checker.sv
module canslp_checker #(
  parameter int NUM_TX = 3
) (
  input logic              busClk,
  input logic              busRstN,
  input logic              canClk,
  input logic              canRstN,
  input logic              sleepReq,
  input logic              sleepAck,
  input logic              wakeIrq,
  input logic [NUM_TX-1:0] txEmpty,
  input logic              rxBusy,
  input logic              protoClkEn
);
  // acknowledge only once the CAN side is really asleep
  p_ack_after_sleep_r5: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(sleepAck) |-> !protoClkEn);

  // entry only with drained buffers and no reception
  p_entry_drained_r3: assert property (@(posedge canClk) disable iff (!canRstN)
    $fell(protoClkEn) |-> ($past(&txEmpty) && !$past(rxBusy)));

  // the engine clock restarts only after the request is withdrawn
  p_exit_on_release_r9: assert property (@(posedge canClk) disable iff (!canRstN)
    $rose(protoClkEn) |-> !sleepReq);

  // a wake flag appears only during an acknowledged sleep
  p_wake_in_sleep_r8: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(wakeIrq) |-> sleepAck);
endmodule

bind canslp_top canslp_checker #(.NUM_TX(NUM_TX)) u_chk (
  .busClk     (busClk),
  .busRstN    (busRstN),
  .canClk     (canClk),
  .canRstN    (canRstN),
  .sleepReq   (sleepReq),
  .sleepAck   (sleepAck),
  .wakeIrq    (wakeIrq),
  .txEmpty    (txEmpty),
  .rxBusy     (rxBusy),
  .protoClkEn (protoClkEn)
);

// File: tb/canslp_top_test.sv
module canslp_top_test;
  localparam int NUM_TX = 3;

  logic busClk, busRstN, sleepReq, wakeEnable, wakeIrqClr, sleepAck, wakeIrq;
  logic canClk, canRstN, rxBusy, busIdle, engineTx, canRxPin;
  logic protoClkEn, txPinOut, rxInternal;
  logic [NUM_TX-1:0] txEmpty;

  int checks = 0;
  int fails  = 0;
  logic expQ[$];
  logic lastAck;
  logic running = 1'b0;

  canslp_top #(.NUM_TX(NUM_TX)) uut (
    .busClk(busClk), .busRstN(busRstN), .sleepReq(sleepReq),
    .wakeEnable(wakeEnable), .wakeIrqClr(wakeIrqClr), .sleepAck(sleepAck),
    .wakeIrq(wakeIrq), .canClk(canClk), .canRstN(canRstN), .txEmpty(txEmpty),
    .rxBusy(rxBusy), .busIdle(busIdle), .engineTx(engineTx),
    .canRxPin(canRxPin), .protoClkEn(protoClkEn), .txPinOut(txPinOut),
    .rxInternal(rxInternal)
  );

  initial begin busClk = 0; forever #5 busClk = ~busClk; end
  initial begin canClk = 0; forever #8 canClk = ~canClk; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWait(input int n);
    for (int i = 0; i < n; i++) @(negedge busClk);
  endtask

  task automatic waitAck(input logic v, input int maxCyc, input string req);
    int n = 0;
    while (sleepAck !== v && n < maxCyc) begin
      @(negedge busClk);
      n++;
    end
    check(sleepAck === v, req, sleepAck, v);
  endtask

  task automatic setReq(input logic v, input logic expectEdge);
    @(negedge busClk);
    if (expectEdge) expQ.push_back(v);
    sleepReq = v;
  endtask

  task automatic driveCan(input logic tx, input logic rx);
    @(negedge canClk);
    engineTx = tx;
    canRxPin = rx;
    #1;
  endtask

  // scoreboard monitor: every acknowledge edge must match the next expected one
  initial begin
    lastAck = 1'b0;
    wait (running);
    forever begin
      @(negedge busClk);
      if (sleepAck !== lastAck) begin
        lastAck = sleepAck;
        if (expQ.size() == 0) check(1'b0, "R5 unexpected ack edge", sleepAck, !sleepAck);
        else begin
          logic e;
          e = expQ.pop_front();
          check(e === sleepAck, "R5 ack edge order", sleepAck, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    busRstN = 0; canRstN = 0; sleepReq = 0; wakeEnable = 0; wakeIrqClr = 0;
    txEmpty = '1; rxBusy = 0; busIdle = 1; engineTx = 1; canRxPin = 1;
    busWait(6);
    busRstN = 1; canRstN = 1;
    running = 1'b1;
    busWait(4);

    // R1 reset state
    check(sleepAck === 0, "R1 ack", sleepAck, 0);
    check(wakeIrq === 0, "R1 irq", wakeIrq, 0);
    check(protoClkEn === 1, "R1 clk enable", protoClkEn, 1);
    driveCan(0, 0);
    check(txPinOut === 0, "R1 tx follows engine", txPinOut, 0);
    check(rxInternal === 0, "R1 rx follows pin", rxInternal, 0);
    driveCan(1, 1);

    // R2 immediate entry, R6 gating, R7 unarmed masking
    setReq(1, 1);
    waitAck(1, 20, "R2 immediate ack");
    check(protoClkEn === 0, "R6 clk enable off", protoClkEn, 0);
    driveCan(0, 0);
    check(txPinOut === 1, "R6 tx recessive", txPinOut, 1);
    check(rxInternal === 1, "R7 rx masked", rxInternal, 1);
    busWait(20);
    check(wakeIrq === 0, "R7 no wake flag", wakeIrq, 0);
    @(negedge busClk); wakeEnable = 1;
    busWait(20);
    check(rxInternal === 1, "R7 late enable still masked", rxInternal, 1);
    check(wakeIrq === 0, "R7 late enable no flag", wakeIrq, 0);
    driveCan(1, 1);
    @(negedge busClk); wakeEnable = 0;

    // R9 leave sleep
    setReq(0, 1);
    waitAck(0, 20, "R9 ack falls");
    check(protoClkEn === 1, "R9 clk enable back", protoClkEn, 1);
    driveCan(0, 1);
    check(txPinOut === 0, "R9 tx follows engine", txPinOut, 0);
    driveCan(1, 1);

    // R3 pending transmit buffer defers entry
    @(negedge canClk); txEmpty = 3'b101;
    setReq(1, 1);
    busWait(40);
    check(sleepAck === 0, "R3 deferred ack", sleepAck, 0);
    check(protoClkEn === 1, "R3 still running", protoClkEn, 1);
    @(negedge canClk); txEmpty = 3'b111;
    waitAck(1, 20, "R3 ack after drain");
    setReq(0, 1);
    waitAck(0, 20, "R3 exit");

    // R4 reception defers entry until idle
    @(negedge canClk); rxBusy = 1; busIdle = 0;
    setReq(1, 1);
    busWait(40);
    check(sleepAck === 0, "R4 busy no ack", sleepAck, 0);
    @(negedge canClk); rxBusy = 0;
    busWait(40);
    check(sleepAck === 0, "R4 not idle no ack", sleepAck, 0);
    @(negedge canClk); busIdle = 1;
    waitAck(1, 20, "R4 ack at idle");
    setReq(0, 1);
    waitAck(0, 20, "R4 exit");

    // R8 armed wake-up
    @(negedge busClk); wakeEnable = 1;
    busWait(10);
    setReq(1, 1);
    waitAck(1, 20, "R8 ack");
    driveCan(1, 0);
    check(rxInternal === 0, "R8 rx passes", rxInternal, 0);
    begin
      int n = 0;
      while (wakeIrq !== 1 && n < 30) begin @(negedge busClk); n++; end
    end
    check(wakeIrq === 1, "R8 wake flag", wakeIrq, 1);
    driveCan(1, 1);
    busWait(5);
    check(wakeIrq === 1, "R8 flag sticky", wakeIrq, 1);
    @(negedge busClk); wakeIrqClr = 1;
    @(negedge busClk); wakeIrqClr = 0;
    check(wakeIrq === 0, "R8 flag cleared", wakeIrq, 0);
    driveCan(1, 0);
    busWait(30);
    check(wakeIrq === 0, "R8 one flag per episode", wakeIrq, 0);
    driveCan(1, 1);
    setReq(0, 1);
    waitAck(0, 20, "R8 exit");
    @(negedge busClk); wakeEnable = 0;

    // R10 withdrawal during deferral
    @(negedge canClk); txEmpty = 3'b011;
    setReq(1, 0);
    busWait(30);
    setReq(0, 0);
    busWait(30);
    @(negedge canClk); txEmpty = 3'b111;
    busWait(40);
    check(sleepAck === 0, "R10 no ack", sleepAck, 0);
    check(protoClkEn === 1, "R10 running", protoClkEn, 1);

    busWait(5);
    check(expQ.size() == 0, "R5 all expected edges seen", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule